// File: doc/BRIEF.md
# Byte-Stream Message Synchroniser

This block sits on the receiving side of a byte stream pulled from a serial receiver's data register. Between messages the source pads the stream with 0xFF idle bytes. The block drops that padding. It finds where each message begins and forwards every byte of the message without changing it. Two kinds of message are recognised. A text message opens with `$` (0x24) and runs through its line feed (0x0A). A binary frame opens with the pair 0xB5 0x62 and carries a little-endian length field, which gives the frame's end. Inside a binary frame a 0xFF byte is payload, so it is forwarded like any other byte.

Both stream interfaces use valid/ready. A byte transfers on a rising clock edge when valid and ready are both high. The upstream side must hold `in_valid` and `in_data` steady until the byte is taken. The output is one register stage. While `out_valid` is high and `out_ready` is low, the output fields stay frozen and `in_ready` stays low, so no byte is lost or repeated. Each forwarded byte carries three qualifiers: a start flag on the first byte of a message, a kind tag, and an end flag on the last byte. Bytes that are dropped between messages and are not padding raise a one-cycle error pulse.

Top module: `msg_sync`

## Requirements
- R1: After a synchronous reset, `out_valid` and `err_stray` are 0, and `in_ready` is 1 whenever `out_ready` is 1.
- R2: A 0xFF byte accepted between messages produces no output beat and no error pulse.
- R3: An accepted 0x24 between messages starts a text message. It is forwarded with `out_som`=1 and `out_type`=0. Every following byte is forwarded up to and including the first 0x0A, which carries `out_last`=1. The block then returns to dropping fill.
- R4: The pair 0xB5 0x62 between messages starts a binary frame. The 0xB5 is forwarded with `out_som`=1 and `out_type`=1, and every frame byte follows in order with `out_type`=1.
- R5: In a binary frame, counting the 0xB5 as offset 0, offset 4 is the low byte and offset 5 the high byte of a payload length L. The frame is 8+L bytes long. Its final byte carries `out_last`=1. Every byte in it, 0xFF included, is forwarded unchanged.
- R6: A 0xB5 between messages that is not followed by 0x62 is dropped and raises one error pulse. The byte after it is then examined again as a possible message start (0xB5 0x24 starts a text message; 0xB5 0xB5 0x62 starts a binary frame).
- R7: Any other byte between messages (not 0xFF, 0x24 or 0xB5) is dropped. `err_stray` goes high for exactly the cycle after the edge that accepted it.
- R8: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and all output fields are held. The output sequence does not depend on the stall pattern.
- R9: `out_som` is 1 only on the first byte of a message. Messages sent back to back with no fill between them are each recognised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte is offered |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Block accepts the offered byte |
| out_valid | output | 1 | Output beat is present |
| out_data | output | 8 | Forwarded message byte |
| out_som | output | 1 | First byte of a message |
| out_type | output | 1 | Message kind: 0 text, 1 binary |
| out_last | output | 1 | Last byte of a message |
| out_ready | input | 1 | Downstream takes the output beat |
| err_stray | output | 1 | One-cycle pulse per dropped non-fill byte |

## Verification
Two events can fall in the same cycle. One is resolving a held 0xB5 against the byte that follows it. The other is an output stall from `out_ready` being low. In that cycle the pending start marker must not be emitted, and the second byte must not be consumed. Random streams provoke this by mixing stray 0xB5 bytes, genuine binary headers and heavy back-pressure, with a random stall pattern. Every forwarded beat is compared with a bench model of the message rules, and the count of error pulses is compared as well. Any beat that is lost, duplicated or wrongly tagged around such a stall shows up as a mismatch.

// File: rtl/msg_sync_pkg.sv
package msg_sync_pkg;
  localparam int BYTE_W = 8;
  localparam int LEN_W  = 2 * BYTE_W;   // length field is two bytes
  localparam int HDR_N  = 6;            // bytes before payload: sync x2, class, id, len x2
  localparam int TAIL_N = 2;            // trailing check bytes

  localparam logic [BYTE_W-1:0] CODE_FILL  = 8'hFF;
  localparam logic [BYTE_W-1:0] CODE_TEXT  = 8'h24;
  localparam logic [BYTE_W-1:0] CODE_SYNCA = 8'hB5;
  localparam logic [BYTE_W-1:0] CODE_SYNCB = 8'h62;
  localparam logic [BYTE_W-1:0] CODE_EOL   = 8'h0A;

  typedef enum logic {
    KIND_TEXT = 1'b0,
    KIND_BIN  = 1'b1
  } msg_kind_e;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_SYNCB = 2'd1,
    ST_TEXT  = 2'd2,
    ST_BIN   = 2'd3
  } sync_state_e;

  typedef struct packed {
    msg_kind_e         kind;
    logic              som;
    logic              last;
    logic [BYTE_W-1:0] data;
  } beat_t;
endpackage

// File: rtl/msg_sync_decode.sv
module msg_sync_decode
  import msg_sync_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  output logic              is_fill,
  output logic              is_text,
  output logic              is_synca,
  output logic              is_syncb,
  output logic              is_eol
);
  always_comb begin
    is_fill  = (byte_i == CODE_FILL);
    is_text  = (byte_i == CODE_TEXT);
    is_synca = (byte_i == CODE_SYNCA);
    is_syncb = (byte_i == CODE_SYNCB);
    is_eol   = (byte_i == CODE_EOL);
  end
endmodule

// File: rtl/msg_sync_binlen.sv
module msg_sync_binlen
  import msg_sync_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,   // sync byte A emitted (offset 0)
  input  logic              step,    // one later frame byte emitted
  input  logic [BYTE_W-1:0] data,
  output logic              at_end   // the byte offered now is the frame's last
);
  localparam int HW    = $clog2(HDR_N + 1);
  localparam int CNT_W = LEN_W + 1;
  localparam logic [HW-1:0] OFS_LO = HW'(HDR_N - 2);
  localparam logic [HW-1:0] OFS_HI = HW'(HDR_N - 1);
  localparam logic [HW-1:0] OFS_PL = HW'(HDR_N);

  logic [HW-1:0]     hdr;
  logic [BYTE_W-1:0] len_lo;
  logic [CNT_W-1:0]  remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr    <= '0;
      len_lo <= '0;
      remain <= '0;
    end else if (start) begin
      hdr <= HW'(1);
    end else if (step) begin
      if (hdr != OFS_PL) begin
        if (hdr == OFS_LO) len_lo <= data;
        if (hdr == OFS_HI) remain <= CNT_W'({data, len_lo}) + CNT_W'(TAIL_N);
        hdr <= hdr + HW'(1);
      end else begin
        remain <= remain - CNT_W'(1);
      end
    end
  end

  assign at_end = (hdr == OFS_PL) && (remain == CNT_W'(1));
endmodule

// File: rtl/msg_sync_obuf.sv
module msg_sync_obuf
  import msg_sync_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load,
  input  beat_t d,
  input  logic  take,
  output logic  valid,
  output beat_t q,
  output logic  free
);
  assign free = !valid || take;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      q     <= '0;
    end else if (free) begin
      valid <= load;
      if (load) q <= d;
    end
  end
endmodule

// File: rtl/msg_sync.sv
module msg_sync
  import msg_sync_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_som,
  output logic              out_type,
  output logic              out_last,
  input  logic              out_ready,
  output logic              err_stray
);
  sync_state_e st, st_n;
  logic  is_fill, is_text, is_synca, is_syncb, is_eol;
  logic  out_free, in_fire, emit, err_c, len_start, len_step, bin_end;
  beat_t nb, ob;

  msg_sync_decode u_dec (
    .byte_i(in_data), .is_fill(is_fill), .is_text(is_text),
    .is_synca(is_synca), .is_syncb(is_syncb), .is_eol(is_eol)
  );

  msg_sync_binlen u_len (
    .clk(clk), .rst(rst), .start(len_start), .step(len_step),
    .data(in_data), .at_end(bin_end)
  );

  msg_sync_obuf u_obuf (
    .clk(clk), .rst(rst), .load(emit), .d(nb), .take(out_ready),
    .valid(out_valid), .q(ob), .free(out_free)
  );

  // the held sync byte A is resolved without consuming the next byte
  assign in_ready = out_free && (st != ST_SYNCB);
  assign in_fire  = in_valid && in_ready;

  always_comb begin
    st_n      = st;
    emit      = 1'b0;
    err_c     = 1'b0;
    len_start = 1'b0;
    len_step  = 1'b0;
    nb.kind   = KIND_TEXT;
    nb.som    = 1'b0;
    nb.last   = 1'b0;
    nb.data   = in_data;
    unique case (st)
      ST_HUNT: if (in_fire) begin
        if (is_text) begin
          emit   = 1'b1;
          nb.som = 1'b1;
          st_n   = ST_TEXT;
        end else if (is_synca) begin
          st_n = ST_SYNCB;
        end else if (!is_fill) begin
          err_c = 1'b1;
        end
      end
      ST_SYNCB: if (in_valid) begin
        if (is_syncb) begin
          if (out_free) begin
            emit      = 1'b1;
            nb.kind   = KIND_BIN;
            nb.som    = 1'b1;
            nb.data   = CODE_SYNCA;
            len_start = 1'b1;
            st_n      = ST_BIN;
          end
        end else begin
          err_c = 1'b1;
          st_n  = ST_HUNT;
        end
      end
      ST_TEXT: if (in_fire) begin
        emit    = 1'b1;
        nb.last = is_eol;
        if (is_eol) st_n = ST_HUNT;
      end
      ST_BIN: if (in_fire) begin
        emit     = 1'b1;
        len_step = 1'b1;
        nb.kind  = KIND_BIN;
        nb.last  = bin_end;
        if (bin_end) st_n = ST_HUNT;
      end
      default: st_n = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_HUNT;
      err_stray <= 1'b0;
    end else begin
      st        <= st_n;
      err_stray <= err_c;
    end
  end

  assign out_data = ob.data;
  assign out_som  = ob.som;
  assign out_type = ob.kind;
  assign out_last = ob.last;
endmodule

// File: rtl/msg_sync_chk.sv
module msg_sync_chk
  import msg_sync_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic [BYTE_W-1:0] out_data,
  input logic              out_som,
  input logic              out_type,
  input logic              out_last,
  input logic              out_ready,
  input logic              err_stray
);
  a_r8_hold_stall: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_som)
                               && $stable(out_type) && $stable(out_last));

  a_r8_no_accept_full: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  a_r3_text_lead: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_som && out_type == KIND_TEXT |-> out_data == CODE_TEXT);

  a_r3_text_close: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_last && out_type == KIND_TEXT |-> out_data == CODE_EOL);

  a_r4_bin_lead: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_som && out_type == KIND_BIN |-> out_data == CODE_SYNCA);

  a_r2_no_fill_lead: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_som |-> out_data != CODE_FILL);

  a_r7_err_after_input: assert property (@(posedge clk) disable iff (rst)
    err_stray |-> $past(in_valid));
endmodule

bind msg_sync msg_sync_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_data(out_data), .out_som(out_som),
  .out_type(out_type), .out_last(out_last), .out_ready(out_ready),
  .err_stray(err_stray)
);

// File: tb/msg_sync_test.sv
module msg_sync_test;
  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid, in_ready, out_valid, out_som, out_type, out_last, out_ready, err_stray;
  logic [7:0] in_data, out_data;

  always #5 clk = ~clk;

  msg_sync uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_som(out_som), .out_type(out_type),
    .out_last(out_last), .out_ready(out_ready), .err_stray(err_stray)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  logic [7:0]  in_q[$];
  logic [10:0] exp_q[$];   // {kind, som, last, data}
  int exp_err;

  task automatic check(string tag, string what, int act, int expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // reference model of the message rules
  task automatic model();
    int st = 0; int pos = 0; int len = 0; logic [7:0] lo = 0;
    exp_q.delete(); exp_err = 0;
    foreach (in_q[i]) begin
      logic [7:0] b = in_q[i];
      bit redo = 1;
      while (redo) begin
        redo = 0;
        case (st)
          0: if (b == 8'h24) begin exp_q.push_back({1'b0, 1'b1, 1'b0, b}); st = 2; end
             else if (b == 8'hB5) st = 1;
             else if (b != 8'hFF) exp_err++;
          1: if (b == 8'h62) begin exp_q.push_back({1'b1, 1'b1, 1'b0, 8'hB5}); st = 3; pos = 1; redo = 1; end
             else begin exp_err++; st = 0; redo = 1; end
          2: begin exp_q.push_back({1'b0, 1'b0, b == 8'h0A, b}); if (b == 8'h0A) st = 0; end
          default: begin
            bit last;
            if (pos == 4) lo = b;
            if (pos == 5) len = int'({b, lo});
            last = (pos >= 7) && (pos == 7 + len);
            exp_q.push_back({1'b1, 1'b0, last, b});
            pos++;
            if (last) st = 0;
          end
        endcase
      end
    end
  endtask

  task automatic gen_text();
    in_q.push_back(8'h24);
    repeat ($urandom_range(0, 10)) in_q.push_back(8'($urandom_range(8'h20, 8'h7E)));
    in_q.push_back(8'h0A);
  endtask

  task automatic gen_bin(int len, int ff_pct);
    in_q.push_back(8'hB5); in_q.push_back(8'h62);
    in_q.push_back(8'($urandom)); in_q.push_back(8'($urandom));
    in_q.push_back(8'(len)); in_q.push_back(8'(len >> 8));
    repeat (len + 2) in_q.push_back(($urandom_range(0, 99) < ff_pct) ? 8'hFF : 8'($urandom));
  endtask

  task automatic run_phase(string tag, int rdy_pct, int gap_pct);
    int idx = 0; int errs = 0; int idle = 0;
    bit acc = 0; bit stall = 0; logic [10:0] prev = 0;
    model();
    while (idx < in_q.size() || exp_q.size() > 0 || idle < 20) begin
      logic [10:0] now;
      @(negedge clk);
      if (acc) begin in_valid = 1'b0; acc = 0; end
      now = {out_type, out_som, out_last, out_data};
      if (err_stray) errs++;
      if (stall) check(tag, "held beat under stall", {out_valid, now}, {1'b1, prev});
      out_ready = ($urandom_range(0, 99) < rdy_pct);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(tag, "unexpected beat", now, 0);
        else check(tag, "beat {kind,som,last,data}", now, exp_q.pop_front());
      end
      stall = out_valid && !out_ready;
      prev  = now;
      if (!in_valid && idx < in_q.size() && $urandom_range(0, 99) >= gap_pct) begin
        in_valid = 1'b1;
        in_data  = in_q[idx];
      end
      #1;
      if (in_valid && in_ready) begin idx++; acc = 1; end
      if (idx == in_q.size() && exp_q.size() == 0) idle++;
    end
    check(tag, "error pulse count", errs, exp_err);
    in_q.delete();
  endtask

  initial begin
    int unsigned seed = 32'h5EED_0042;
    void'($urandom(seed));
    rst = 1'b1; in_valid = 1'b0; in_data = 8'h00; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1", "out_valid", out_valid, 0);
    check("R1", "err_stray", err_stray, 0);
    check("R1", "in_ready", in_ready, 1);

    // R3: text message framed by fill
    in_q = '{8'hFF, 8'hFF, 8'hFF, 8'h24, 8'h47, 8'h50, 8'h0A, 8'hFF, 8'hFF};
    run_phase("R3", 100, 0);

    // R4: binary frame with 0xFF inside payload
    gen_bin(3, 60); in_q.push_back(8'hFF);
    run_phase("R4", 100, 0);

    // R5: zero-length frame, then a frame whose payload and check bytes are all 0xFF
    gen_bin(0, 0); gen_bin(2, 100); gen_bin(300, 30); in_q.push_back(8'hFF);
    run_phase("R5", 80, 10);

    // R6: stray sync byte then text; double sync byte then frame; stray before fill
    in_q = '{8'hB5, 8'h24, 8'h41, 8'h0A, 8'hB5};
    gen_bin(1, 50);
    in_q.push_back(8'hB5); in_q.push_back(8'hFF); in_q.push_back(8'hB5); in_q.push_back(8'h41);
    run_phase("R6", 100, 0);

    // R7: junk between messages
    in_q = '{8'h41, 8'h00, 8'h62, 8'hFF, 8'h0A};
    gen_text(); in_q.push_back(8'h7E);
    run_phase("R7", 100, 0);

    // R2: long fill runs around a frame
    repeat (40) in_q.push_back(8'hFF);
    gen_bin(4, 50);
    repeat (40) in_q.push_back(8'hFF);
    run_phase("R2", 100, 20);

    // R9: back-to-back messages with no fill
    gen_text(); gen_text(); gen_bin(2, 20); gen_text(); gen_bin(0, 0);
    run_phase("R9", 100, 0);

    // R8: random mixture under heavy back-pressure, stray sync bytes included
    for (int p = 0; p < 6; p++) begin
      repeat (40) begin
        case ($urandom_range(0, 5))
          0: gen_text();
          1: gen_bin($urandom_range(0, 24), 30);
          2: repeat ($urandom_range(1, 5)) in_q.push_back(8'hFF);
          3: in_q.push_back(8'($urandom_range(8'h00, 8'h23)));
          4: begin in_q.push_back(8'hB5); in_q.push_back(($urandom_range(0, 1) == 1) ? 8'hB5 : 8'h24); end
          default: begin in_q.push_back(8'hB5); in_q.push_back(8'h62); in_q.push_back(8'h01);
                         in_q.push_back(8'h02); in_q.push_back(8'h01); in_q.push_back(8'h00);
                         repeat (3) in_q.push_back(8'hFF); end
        endcase
      end
      in_q.push_back(8'hFF); in_q.push_back(8'hFF);
      gen_text();
      run_phase("R8", 25 + p * 12, p * 8);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule